// File: doc/BRIEF.md
# Constant-Extended Final-Stage Prefix Adder

This block is the closing addition of a residue-to-binary conversion datapath. It adds a wide operand of 4N+1 bits to a short operand of 2N+1 bits. The short operand is widened by placing 2N constant ones above it. Because those upper bits are fixed, only the low 2N+1 positions need a full parallel-prefix carry network. The upper 2N bits of the result reduce to a copy of the wide operand's upper field, or that field minus one, depending on a single carry out of the low field.

Widening with ones is the same as sign-extending a negative two's-complement value. The stage therefore performs a subtraction: the caller passes the short operand as the two's complement of the amount to subtract. The block has no clock and no registers, and the result follows the inputs in the same cycle. N sets every width. A style parameter chooses how the zero-run detector behind the upper decrement is built: a logarithmic prefix tree or a serial chain.

Top module: `rns_final_adder`

## Requirements
- R1: For every input pair, `sum_o` equals (`opa_i` + {2N ones, `opb_i`}) modulo 2^(4N+1).
- R2: Bits [2N:0] of `sum_o` equal (`opa_i[2N:0]` + `opb_i`) modulo 2^(2N+1).
- R3: When `opa_i[2N:0]` + `opb_i` is at least 2^(2N+1), bits [4N:2N+1] of `sum_o` equal `opa_i[4N:2N+1]` unchanged.
- R4: When `opa_i[2N:0]` + `opb_i` is below 2^(2N+1), bits [4N:2N+1] of `sum_o` equal `opa_i[4N:2N+1]` minus one modulo 2^(2N). An upper field of zero wraps to all ones, so all-zero inputs give 2^(4N+1) − 2^(2N+1).
- R5: A carry out of bit 4N is dropped. All-ones inputs give 2^(4N+1) − 2.
- R6: For any X from 1 to 2^(2N+1), driving `opb_i` = (2^(2N+1) − X) mod 2^(2N+1) gives `sum_o` = (`opa_i` − X) mod 2^(4N+1).
- R7: The prefix-tree and serial-chain decrement styles give identical `sum_o` for identical inputs.
- R8: `sum_o` settles to its new value after an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 4N+1 | Wide operand |
| opb_i | input | 2N+1 | Short operand, extended above by 2N ones |
| sum_o | output | 4N+1 | Result modulo 2^(4N+1) |

## Verification
The only internal decision is the low-field carry. A wrong carry, or a broken zero-run detector, appears at once as an upper field that is off by one: either missing a decrement or decremented when it should not be. A fault inside the prefix tree shows up as wrong low-field bits for operand pairs whose carries travel far. For that reason the stimulus sweeps the whole short operand against low parts of zero, all ones and mid-range values. Each fault is visible in the same time step as the input that triggers it.

// File: rtl/rfa_pkg.sv
package rfa_pkg;

   typedef enum logic [0:0] {
      DEC_PREFIX = 1'b0,
      DEC_RIPPLE = 1'b1
   } dec_style_e;

   function automatic int unsigned prefix_levels(input int unsigned width);
      int unsigned lv;
      lv = 0;
      while ((1 << lv) < width) lv++;
      if (lv == 0) lv = 1;
      return lv;
   endfunction

endpackage

// File: rtl/rfa_ks_adder.sv
module rfa_ks_adder #(
   parameter int unsigned W = 11
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   output logic [W-1:0] sum_o,
   output logic         cout_o
);
   localparam int unsigned LV = rfa_pkg::prefix_levels(W);

   logic [LV:0][W-1:0] gen_t;
   logic [LV:0][W-1:0] prp_t;
   logic               unused_prp;

   // pre-processing: bitwise generate and propagate
   assign gen_t[0] = x_i & y_i;
   assign prp_t[0] = x_i ^ y_i;

   // prefix carry tree
   for (genvar k = 0; k < LV; k++) begin : g_lvl
      localparam int unsigned D = 1 << k;
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (i < D) begin : g_pass
            assign gen_t[k+1][i] = gen_t[k][i];
            assign prp_t[k+1][i] = prp_t[k][i];
         end else begin : g_cell
            assign gen_t[k+1][i] = gen_t[k][i] | (prp_t[k][i] & gen_t[k][i-D]);
            assign prp_t[k+1][i] = prp_t[k][i] & prp_t[k][i-D];
         end
      end
   end

   // post-processing: sum from propagate and incoming carry
   assign sum_o[0] = prp_t[0][0];
   for (genvar i = 1; i < W; i++) begin : g_sum
      assign sum_o[i] = prp_t[0][i] ^ gen_t[LV][i-1];
   end

   assign cout_o     = gen_t[LV][W-1];
   assign unused_prp = ^prp_t[LV];

endmodule

// File: rtl/rfa_zero_dec.sv
module rfa_zero_dec
   import rfa_pkg::*;
#(
   parameter int unsigned U     = 10,
   parameter dec_style_e  STYLE = DEC_PREFIX
) (
   input  logic [U-1:0] x_i,
   input  logic         dec_i,
   output logic [U-1:0] y_o
);
   logic [U-1:0] nz;
   logic [U-1:0] zrun;

   assign nz = ~x_i;

   if (STYLE == DEC_PREFIX) begin : g_tree
      localparam int unsigned LV = prefix_levels(U);
      logic [LV:0][U-1:0] all0;
      logic               unused_top;

      assign all0[0] = nz;
      for (genvar k = 0; k < LV; k++) begin : g_lvl
         localparam int unsigned D = 1 << k;
         for (genvar i = 0; i < U; i++) begin : g_bit
            if (i < D) begin : g_pass
               assign all0[k+1][i] = all0[k][i];
            end else begin : g_cell
               assign all0[k+1][i] = all0[k][i] & all0[k][i-D];
            end
         end
      end
      assign zrun       = {all0[LV][U-2:0], 1'b1};
      assign unused_top = all0[LV][U-1];
   end else begin : g_chain
      logic unused_msb;
      assign zrun[0] = 1'b1;
      for (genvar i = 1; i < U; i++) begin : g_bit
         assign zrun[i] = zrun[i-1] & nz[i-1];
      end
      assign unused_msb = nz[U-1];
   end

   // a bit flips when decrementing and every bit below it is zero
   assign y_o = x_i ^ ({U{dec_i}} & zrun);

endmodule

// File: rtl/rns_final_adder.sv
module rns_final_adder
   import rfa_pkg::*;
#(
   parameter int unsigned N         = 5,
   parameter dec_style_e  DEC_STYLE = DEC_PREFIX
) (
   input  logic [4*N:0] opa_i,
   input  logic [2*N:0] opb_i,
   output logic [4*N:0] sum_o
);
   localparam int unsigned W_LO = 2*N + 1;
   localparam int unsigned W_HI = 2*N;

   if (N < 1) begin : g_bad_n
      $error("rns_final_adder: N must be at least 1");
   end

   logic [W_LO-1:0] lo_sum;
   logic            lo_carry;
   logic [W_HI-1:0] hi_sum;

   rfa_ks_adder #(.W(W_LO)) u_lo (
      .x_i   (opa_i[W_LO-1:0]),
      .y_i   (opb_i),
      .sum_o (lo_sum),
      .cout_o(lo_carry)
   );

   // constant ones above: upper = A_hi - 1 + carry
   rfa_zero_dec #(.U(W_HI), .STYLE(DEC_STYLE)) u_hi (
      .x_i  (opa_i[4*N:W_LO]),
      .dec_i(~lo_carry),
      .y_o  (hi_sum)
   );

   assign sum_o = {hi_sum, lo_sum};

endmodule

module rns_final_adder_chk #(
   parameter int unsigned N = 5
) (
   input logic [4*N:0] opa_i,
   input logic [2*N:0] opb_i,
   input logic [4*N:0] sum_o,
   input logic         lo_carry_i
);
   localparam int unsigned WF = 4*N + 1;
   localparam int unsigned WL = 2*N + 1;

   logic [WF:0]   ref_full;
   logic [WL:0]   ref_lo;
   logic [WF-1:0] ext_b;
   logic [WF-1:0] upper_a;
   logic [WF-1:0] upper_s;

   always_comb begin
      ext_b    = {{(WF-WL){1'b1}}, opb_i};
      ref_full = {1'b0, opa_i} + {1'b0, ext_b};
      ref_lo   = {1'b0, opa_i[WL-1:0]} + {1'b0, opb_i};
      upper_a  = opa_i >> WL;
      upper_s  = sum_o >> WL;
      if (!$isunknown({opa_i, opb_i})) begin
         // R1
         full_sum_chk: assert (sum_o == ref_full[WF-1:0])
            else $error("full sum mismatch");
         // R2
         low_field_chk: assert (sum_o[WL-1:0] == ref_lo[WL-1:0])
            else $error("low field mismatch");
         // R3
         upper_keep_chk: assert (!ref_lo[WL] || (upper_s == upper_a))
            else $error("upper field changed despite carry");
         // R4
         upper_dec_chk: assert (ref_lo[WL] || (upper_s[WF-WL-1:0] == upper_a[WF-WL-1:0] - 1'b1))
            else $error("upper field not decremented");
         // R3
         carry_route_chk: assert (lo_carry_i == ref_lo[WL])
            else $error("low carry wrong");
      end
   end
endmodule

bind rns_final_adder rns_final_adder_chk #(.N(N)) u_chk (
   .opa_i     (opa_i),
   .opb_i     (opb_i),
   .sum_o     (sum_o),
   .lo_carry_i(lo_carry)
);

// File: tb/sim_rns_final_adder.sv
module sim_rns_final_adder;
   import rfa_pkg::*;

   localparam int unsigned N          = 5;
   localparam int unsigned WF         = 4*N + 1;
   localparam int unsigned WL         = 2*N + 1;
   localparam int          CLK_PERIOD = 10;
   localparam int          WATCHDOG   = 150000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [WF-1:0] opa = '0;
   logic [WL-1:0] opb = '0;
   logic [WF-1:0] sum_p, sum_r;
   int            n_checks = 0;
   int            n_errors = 0;
   int            cycles   = 0;
   bit            done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rns_final_adder #(.N(N), .DEC_STYLE(DEC_PREFIX)) u0 (
      .opa_i(opa), .opb_i(opb), .sum_o(sum_p));
   rns_final_adder #(.N(N), .DEC_STYLE(DEC_RIPPLE)) u1 (
      .opa_i(opa), .opb_i(opb), .sum_o(sum_r));

   task automatic check(input string req, input logic [WF-1:0] act, input logic [WF-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h (a=%h b=%h)", req, act, exp, opa, opb);
      end
   endtask

   function automatic logic [WF-1:0] ref_sum(input logic [WF-1:0] a, input logic [WL-1:0] b);
      logic [WF-1:0] ones_hi;
      ones_hi = ~(WF'((1 << WL) - 1));
      return a + (ones_hi | WF'(b));
   endfunction

   // drive off the rising edge; sample 1 time unit later, no edge between (R8)
   task automatic apply(input logic [WF-1:0] a, input logic [WL-1:0] b);
      int unsigned lo_total;
      logic [WF-1:0] hi_a, hi_s;
      @(negedge clk);
      opa = a;
      opb = b;
      #1;
      lo_total = int'(a[WL-1:0]) + int'(b);
      hi_a = a >> WL;
      hi_s = sum_p >> WL;
      check("R1", sum_p, ref_sum(a, b));
      check("R2", WF'(sum_p[WL-1:0]), WF'(lo_total[WL-1:0]));
      if (lo_total >= (1 << WL)) check("R3", hi_s, hi_a);
      else check("R4", hi_s, (hi_a - 1) & WF'((1 << (WF-WL)) - 1));
      check("R7", sum_r, sum_p);
   endtask

   initial begin
      logic [WF-1:0] pats [16];
      repeat (2) @(posedge clk);
      rst = 1'b0;
      // zero inputs: upper wraps to all ones (R4)
      apply('0, '0);
      check("R4", sum_p, WF'((1 << WF) - (1 << WL)));
      // R5 carry out of the top bit dropped
      apply('1, '1);
      check("R5", sum_p, WF'((1 << WF) - 2));
      // R8 new value after change without a clock edge
      @(negedge clk);
      opa = WF'(12345);
      opb = WL'(7);
      #1;
      check("R8", sum_p, ref_sum(WF'(12345), WL'(7)));
      // R3 / R4 boundary: low sum exactly 2^WL vs one below
      apply(WF'(1 << WL) | WF'(1), '1);
      check("R3", sum_p, WF'(1 << WL));
      apply(WF'(1 << WL), '1);
      check("R4", sum_p, WF'((1 << WL) - 1));
      // R6 subtraction through two's complement
      for (int x = 1; x <= (1 << WL); x += 97) begin
         for (int k = 0; k < 4; k++) begin
            logic [WF-1:0] a;
            a = (k == 0) ? WF'(5) : (k == 1) ? WF'(1000000) : (k == 2) ? '1 : WF'($urandom);
            apply(a, WL'((1 << WL) - x));
            check("R6", sum_p, a - WF'(x));
         end
      end
      apply(WF'(777777), '0);
      check("R6", sum_p, WF'(777777) - WF'(1 << WL));
      // sweep every short operand against a set of wide operands
      pats[0] = '0;                pats[1] = '1;
      pats[2] = WF'(1);            pats[3] = WF'((1 << WL) - 1);
      pats[4] = WF'(1 << WL);      pats[5] = ~WF'((1 << WL) - 1);
      pats[6] = WF'(1 << (WF-1));  pats[7] = WF'(1 << (WF-1)) | WF'((1 << WL) - 1);
      pats[8] = WF'(21'h155555);   pats[9] = WF'(21'h0AAAAA);
      for (int p = 10; p < 16; p++) pats[p] = WF'($urandom);
      for (int p = 0; p < 16; p++) begin
         for (int b = 0; b < (1 << WL); b++) apply(pats[p], WL'(b));
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG && !done) begin
         n_checks++;
         n_errors++;
         $display("FAIL R8 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule